// File: doc/BRIEF.md
# Flash Chunk ECC Syndrome Checker and Bit Fixer

This block checks a 256-byte flash data chunk against its error-correcting code. It takes the 22-bit code computed while the data streamed in and the 22-bit code read back from the spare area, and XORs them into a syndrome. It then sorts the result into one of four classes. The chunk is clean. The stored code itself took a hit. The data carries one flipped bit that can be repaired. Or the damage is beyond repair. For a repairable chunk it reports the failing byte and bit.

A 512-byte chunk is checked as two 256-byte halves in consecutive steps. The second half uses its own pair of codes and its byte positions are offset by 256. The overall failure flag is the OR of the two halves. When the repair port is built in, the block repairs each correctable half itself. It reads the failing byte from the data buffer, flips the bit, and writes the byte back before it signals completion.

Top module: `ecc22_fixup`

## Requirements
- R1: If the syndrome is zero, or the computed code is all zero, or the stored code is all zero, the half reports status 0 (clean), counts as no failure and causes no buffer access.
- R2: If the syndrome has exactly one bit set, the half reports status 1 (code damaged) and counts as a failure. The buffer is not read or written.
- R3: If the syndrome has exactly 11 bits set and the pair check holds, the half reports status 2 (repairable). The pair check is that (computed[10:0]^computed[21:11]) XOR (stored[10:0]^stored[21:11]) equals 11'h7FF. For status 2, res_bit equals syndrome[2:0] and res_byte[7:0] equals syndrome[10:3].
- R4: Every other syndrome reports status 3 (beyond repair) and counts as a failure.
- R5: Fixed latency. res_valid for the first half is high in the cycle after the clock edge that accepts req_valid. Each later step follows the previous one with no gap. done is high for exactly one cycle, in the cycle after the last step.
- R6: With req_wide high, a second check follows on calc_b/stored_b and reports res_byte[8]=1 (offset 256). fail at done is the OR of both halves' failures. With req_wide low, only calc_a/stored_a are checked and res_byte[8]=0.
- R7: For each status-2 half, the cycle after its report drives mem_rd_en with mem_addr={half,byte}. The cycle after that drives mem_wr_en at the same address, with mem_wr_data = mem_rd_data XOR (1<<bit). mem_rd_data is returned one cycle after mem_rd_en.
- R8: A req_valid that arrives while a check is in progress is ignored. The running sequence, its results and the buffer are unchanged.
- R9: After reset, res_valid, done, mem_rd_en and mem_wr_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start strobe, accepted only when idle |
| req_wide | input | 1 | 1: 512-byte chunk (two halves), 0: 256-byte chunk |
| calc_a | input | 22 | Computed code, first half |
| stored_a | input | 22 | Stored code, first half |
| calc_b | input | 22 | Computed code, second half |
| stored_b | input | 22 | Stored code, second half |
| res_valid | output | 1 | Per-half result strobe |
| res_status | output | 2 | 0 clean, 1 code damaged, 2 repairable, 3 beyond repair |
| res_byte | output | 9 | Failing byte within the chunk (bit 8 = second half) |
| res_bit | output | 3 | Failing bit within the byte |
| done | output | 1 | One-cycle end-of-chunk strobe |
| fail | output | 1 | Chunk failure flag, valid while done is high |
| mem_rd_en | output | 1 | Buffer byte read request |
| mem_addr | output | 9 | Buffer byte address |
| mem_rd_data | input | 8 | Buffer read data, one cycle after mem_rd_en |
| mem_wr_en | output | 1 | Buffer byte write strobe |
| mem_wr_data | output | 8 | Repaired byte |

## Verification
The first half's result is due in the cycle right after the accepting edge. A repairable half adds one read cycle and then one write cycle. The second half of a wide chunk follows at once, and done comes one cycle after the last step. So each outcome has a fixed cycle count. From the stimulus, the bench builds the exact list of steps it expects, one per cycle. It then samples the strobes at the falling edge of every cycle and compares all four against that list. At the end of each chunk the whole buffer is compared with a reference copy, so any write that should not have happened is caught.

// File: rtl/ecc22_pkg.sv
package ecc22_pkg;
    localparam int CODE_W     = 22;
    localparam int HALF_W     = CODE_W / 2;
    localparam int BIT_W      = 3;
    localparam int BYTE_W     = HALF_W - BIT_W;
    localparam int HALVES     = 2;
    localparam int SEL_W      = $clog2(HALVES);
    localparam int ADDR_W     = BYTE_W + SEL_W;
    localparam int DATA_W     = 1 << BIT_W;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_CODE_ERR = 2'd1,
        ST_FIXED    = 2'd2,
        ST_UNCORR   = 2'd3
    } chk_status_e;

    typedef struct packed {
        chk_status_e         status;
        logic [BYTE_W-1:0]   byte_idx;
        logic [BIT_W-1:0]    bit_idx;
    } chk_result_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_CHECK, SQ_READ, SQ_WRITE, SQ_FINISH
    } seq_state_e;

    function automatic int unsigned ones(input code_t v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < CODE_W; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic is_fail(input chk_status_e s);
        return (s == ST_CODE_ERR) || (s == ST_UNCORR);
    endfunction
endpackage

// File: rtl/ecc22_classify.sv
module ecc22_classify
    import ecc22_pkg::*;
(
    input  code_t       calc_i,
    input  code_t       stor_i,
    output chk_result_t res_o
);
    code_t             syn;
    logic [HALF_W-1:0] pair;
    int unsigned       weight;

    always_comb begin
        syn    = calc_i ^ stor_i;
        weight = ones(syn);
        pair   = (calc_i[HALF_W-1:0] ^ calc_i[CODE_W-1:HALF_W])
               ^ (stor_i[HALF_W-1:0] ^ stor_i[CODE_W-1:HALF_W]);
        res_o.byte_idx = syn[HALF_W-1:BIT_W];
        res_o.bit_idx  = syn[BIT_W-1:0];
        if (syn == '0 || calc_i == '0 || stor_i == '0)
            res_o.status = ST_CLEAN;
        else if (weight == 1)
            res_o.status = ST_CODE_ERR;
        else if (weight == HALF_W && pair == '1)
            res_o.status = ST_FIXED;
        else
            res_o.status = ST_UNCORR;
    end
endmodule

// File: rtl/ecc22_patch.sv
module ecc22_patch
    import ecc22_pkg::*;
(
    input  logic [SEL_W-1:0]  half_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BIT_W-1:0]  bit_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    always_comb begin
        addr_o    = {half_i, byte_i};
        wr_data_o = rd_data_i ^ (DATA_W'(1) << bit_i);
    end
endmodule

// File: rtl/ecc22_fixup.sv
module ecc22_fixup
    import ecc22_pkg::*;
#(
    parameter bit FIX_EN = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_wide,
    input  logic [CODE_W-1:0]     calc_a,
    input  logic [CODE_W-1:0]     stored_a,
    input  logic [CODE_W-1:0]     calc_b,
    input  logic [CODE_W-1:0]     stored_b,
    output logic                  res_valid,
    output logic [1:0]            res_status,
    output logic [ADDR_W-1:0]     res_byte,
    output logic [BIT_W-1:0]      res_bit,
    output logic                  done,
    output logic                  fail,
    output logic                  mem_rd_en,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic [DATA_W-1:0]     mem_rd_data,
    output logic                  mem_wr_en,
    output logic [DATA_W-1:0]     mem_wr_data
);
    seq_state_e       state;
    logic [SEL_W-1:0] half_q;
    logic             wide_q;
    logic             fail_q;
    code_t            calc_q [HALVES];
    code_t            stor_q [HALVES];
    chk_result_t      res_h  [HALVES];
    chk_result_t      cur;
    logic             more_half;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        ecc22_classify u_cls (
            .calc_i (calc_q[h]),
            .stor_i (stor_q[h]),
            .res_o  (res_h[h])
        );
    end

    assign cur       = res_h[half_q];
    assign more_half = wide_q && (half_q == SEL_W'(0));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            half_q <= '0;
            wide_q <= 1'b0;
            fail_q <= 1'b0;
            for (int h = 0; h < HALVES; h++) begin
                calc_q[h] <= '0;
                stor_q[h] <= '0;
            end
        end else begin
            case (state)
                SQ_IDLE: if (req_valid) begin
                    calc_q[0] <= calc_a;
                    stor_q[0] <= stored_a;
                    calc_q[1] <= calc_b;
                    stor_q[1] <= stored_b;
                    wide_q    <= req_wide;
                    half_q    <= '0;
                    fail_q    <= 1'b0;
                    state     <= SQ_CHECK;
                end
                SQ_CHECK: begin
                    fail_q <= fail_q | is_fail(cur.status);
                    if (FIX_EN && cur.status == ST_FIXED)
                        state <= SQ_READ;
                    else if (more_half)
                        half_q <= half_q + SEL_W'(1);
                    else
                        state <= SQ_FINISH;
                end
                SQ_READ:  state <= SQ_WRITE;
                SQ_WRITE: begin
                    if (more_half) begin
                        half_q <= half_q + SEL_W'(1);
                        state  <= SQ_CHECK;
                    end else begin
                        state  <= SQ_FINISH;
                    end
                end
                SQ_FINISH: state <= SQ_IDLE;
                default:   state <= SQ_IDLE;
            endcase
        end
    end

    assign res_valid  = (state == SQ_CHECK);
    assign res_status = cur.status;
    assign res_byte   = {half_q, cur.byte_idx};
    assign res_bit    = cur.bit_idx;
    assign done       = (state == SQ_FINISH);
    assign fail       = fail_q;
    assign mem_rd_en  = (state == SQ_READ);
    assign mem_wr_en  = (state == SQ_WRITE);

    if (FIX_EN) begin : g_fix
        ecc22_patch u_patch (
            .half_i    (half_q),
            .byte_i    (cur.byte_idx),
            .bit_i     (cur.bit_idx),
            .rd_data_i (mem_rd_data),
            .addr_o    (mem_addr),
            .wr_data_o (mem_wr_data)
        );

        // R7: a repairable report is followed at once by a buffer read
        a_r7_fixed_reads: assert property (@(posedge clk) disable iff (rst)
            (res_valid && res_status == ST_FIXED) |=> mem_rd_en);
    end else begin : g_nofix
        assign mem_addr    = '0;
        assign mem_wr_data = '0;
    end

    // R7: read is followed by a write to the same address
    a_r7_rd_then_wr: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> (mem_wr_en && mem_addr == $past(mem_addr)));
    a_r7_wr_after_rd: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> $past(mem_rd_en));
    // R2 / R4: failing halves never touch the buffer
    a_r2_no_touch: assert property (@(posedge clk) disable iff (rst)
        (res_valid && is_fail(chk_status_e'(res_status))) |=> !mem_rd_en);
    // R5: done is a single-cycle pulse that returns to idle
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !res_valid && !mem_rd_en));
    // R6: second-half report only occurs in wide mode
    a_r6_second_half: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_byte[ADDR_W-1]) |-> wide_q);
endmodule

// File: tb/ecc22_fixup_bench.sv
`timescale 1ns/1ps
module ecc22_fixup_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_wide;
    logic [21:0] calc_a, stored_a, calc_b, stored_b;
    logic        res_valid, done, fail, mem_rd_en, mem_wr_en;
    logic [1:0]  res_status;
    logic [8:0]  res_byte, mem_addr;
    logic [2:0]  res_bit;
    logic [7:0]  mem_rd_data, mem_wr_data;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [7:0] mem     [512];
    logic [7:0] ref_mem [512];

    always #4 clk = ~clk;

    ecc22_fixup u_ecc22_fixup (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_wide(req_wide),
        .calc_a(calc_a), .stored_a(stored_a), .calc_b(calc_b), .stored_b(stored_b),
        .res_valid(res_valid), .res_status(res_status), .res_byte(res_byte),
        .res_bit(res_bit), .done(done), .fail(fail), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
        .mem_wr_data(mem_wr_data)
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_addr];
        if (mem_wr_en) mem[mem_addr] <= mem_wr_data;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic void ref_cls(input logic [21:0] c, input logic [21:0] s,
                                    output int st, output int loc);
        logic [21:0] x;
        int n;
        x = c ^ s;
        n = 0;
        for (int i = 0; i < 22; i++) if (x[i]) n++;
        if (x == 0 || c == 0 || s == 0) st = 0;
        else if (n == 1) st = 1;
        else if (n == 11 && (((c[10:0] ^ c[21:11]) ^ (s[10:0] ^ s[21:11])) == 11'h7FF)) st = 2;
        else st = 3;
        loc = int'(x[10:0]);
    endfunction

    // step codes: kind*2 + half; kinds 0 report, 1 read, 2 write, 3 finish
    task automatic run(input logic [21:0] ca, input logic [21:0] sa,
                       input logic [21:0] cb, input logic [21:0] sb,
                       input bit wide, input bit poke, input string tag);
        int st[2];
        int loc[2];
        int q[$];
        bit efail;
        int kind, h, a, mbad;
        ref_cls(ca, sa, st[0], loc[0]);
        ref_cls(cb, sb, st[1], loc[1]);
        efail = 0;
        for (int i = 0; i <= int'(wide); i++) begin
            q.push_back(i);
            if (st[i] == 2) begin q.push_back(2 + i); q.push_back(4 + i); end
            if (st[i] == 1 || st[i] == 3) efail = 1;
        end
        q.push_back(6);
        @(negedge clk);
        req_valid = 1; req_wide = wide;
        calc_a = ca; stored_a = sa; calc_b = cb; stored_b = sb;
        @(negedge clk);
        if (poke) begin
            calc_a = ~ca; stored_a = sa ^ 22'h1; calc_b = 22'h0; req_wide = ~wide;
        end else req_valid = 0;
        foreach (q[k]) begin
            kind = q[k] / 2; h = q[k] % 2;
            chk({res_valid, mem_rd_en, mem_wr_en, done} == {kind == 0, kind == 1, kind == 2, kind == 3},
                (poke ? "R8" : "R5"), {tag, " strobes"},
                int'({res_valid, mem_rd_en, mem_wr_en, done}),
                int'({kind == 0, kind == 1, kind == 2, kind == 3}));
            if (kind == 0) begin
                chk(int'(res_status) == st[h], st[h] == 0 ? "R1" : st[h] == 1 ? "R2" : st[h] == 2 ? "R3" : "R4",
                    {tag, " status"}, int'(res_status), st[h]);
                if (st[h] == 2) begin
                    chk(int'(res_byte) == h * 256 + loc[h] / 8, h ? "R6" : "R3", {tag, " byte"},
                        int'(res_byte), h * 256 + loc[h] / 8);
                    chk(int'(res_bit) == loc[h] % 8, "R3", {tag, " bit"}, int'(res_bit), loc[h] % 8);
                end
            end else if (kind == 1) begin
                chk(int'(mem_addr) == h * 256 + loc[h] / 8, "R7", {tag, " rd addr"},
                    int'(mem_addr), h * 256 + loc[h] / 8);
            end else if (kind == 2) begin
                a = h * 256 + loc[h] / 8;
                chk(int'(mem_addr) == a && mem_wr_data == (ref_mem[a] ^ (8'd1 << (loc[h] % 8))),
                    "R7", {tag, " wr data"}, int'(mem_wr_data), int'(ref_mem[a] ^ (8'd1 << (loc[h] % 8))));
                ref_mem[a] = ref_mem[a] ^ (8'd1 << (loc[h] % 8));
            end else begin
                chk(fail == efail, wide ? "R6" : "R2", {tag, " fail"}, int'(fail), int'(efail));
            end
            @(negedge clk);
            req_valid = 0;
        end
        chk(!res_valid && !done && !mem_rd_en && !mem_wr_en, "R5", {tag, " idle after done"},
            int'({res_valid, done}), 0);
        mbad = 0;
        for (int i = 0; i < 512; i++) if (mem[i] !== ref_mem[i]) mbad++;
        chk(mbad == 0, poke ? "R8" : "R7", {tag, " buffer contents"}, mbad, 0);
    endtask

    function automatic logic [21:0] fix_syn(input logic [10:0] l);
        return {~l, l};
    endfunction

    initial begin
        #(8 * 20000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [21:0] s1, s2;
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        rst = 1; req_valid = 0; req_wide = 0;
        calc_a = 0; stored_a = 0; calc_b = 0; stored_b = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!res_valid && !done && !mem_rd_en && !mem_wr_en, "R9", "reset strobes",
            int'({res_valid, done, mem_rd_en, mem_wr_en}), 0);
        s1 = 22'h15A3C7; s2 = 22'h2B1E04;
        run(s1, s1, 0, 0, 0, 0, "R1 equal codes");
        run(22'h0, s1, 0, 0, 0, 0, "R1 computed zero");
        run(s2, 22'h0, 0, 0, 0, 0, "R1 stored zero");
        run(s1 ^ 22'h000020, s1, 0, 0, 0, 0, "R2 single bit");
        run(s1 ^ 22'h200000, s1, 0, 0, 0, 0, "R2 top bit");
        run(s1 ^ fix_syn(11'h2A5), s1, 0, 0, 0, 0, "R3 repair");
        run(s1 ^ fix_syn(11'h000), s1, 0, 0, 0, 0, "R3 byte0 bit0");
        run(s1 ^ fix_syn(11'h7FF), s1, 0, 0, 0, 0, "R3 byte255 bit7");
        run(s1 ^ 22'h000003, s1, 0, 0, 0, 0, "R4 two bits");
        run(s1 ^ {11'h0FF, 11'h007}, s1, 0, 0, 0, 0, "R4 eleven no pair");
        run(s1, s1, s2 ^ fix_syn(11'h013), s2, 1, 0, "R6 clean then repair");
        run(s1 ^ fix_syn(11'h155), s1, s2 ^ 22'h000005, s2, 1, 0, "R6 repair then bad");
        run(s1 ^ fix_syn(11'h0F1), s1, s2 ^ fix_syn(11'h70E), s2, 1, 0, "R6 two repairs");
        run(s1 ^ 22'h000400, s1, s2, s2, 1, 0, "R6 code err then clean");
        run(s1 ^ fix_syn(11'h3C9), s1, 0, 0, 0, 1, "R8 busy request");
        run(s1, s1, s2 ^ 22'h1, s2, 1, 1, "R8 busy wide");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule